// File: doc/BRIEF.md
# Micro-op Stream Interrupt Injector

This block sits in the front-end micro-op stream. Each arriving micro-op carries an opcode, the address of its parent instruction, the address at which execution would resume after it, and three tag bits: end of instruction, interruptible point, and synchronous exception. An external interrupt request is latched. It is delivered by merging one unconditional jump micro-op into the outgoing stream. The jump targets a handler address given at a port, and its return field carries the resume address of the last micro-op that opened an injection point.

A jump may only follow a micro-op that closes an instruction, marks a safe point inside a long-running instruction, or is a branch. A jump is never placed between two micro-ops of the same instruction. While the jump is offered, the input is stalled, so no stream micro-op is lost or repeated. Exception-tagged micro-ops travel through unchanged, and they never open an injection point, so that the exception stays exactly where it occurred in program order. A global enable gates delivery. Requests made while the enable is low are kept.

Top module: `uop_irq_injector`

## Requirements
- R1: After reset the stream counts as being at a boundary, with resume address RESET_PC. Nothing is pending, out_valid follows in_valid, irq_ack is low, and a request made straight after reset is injected with out_ret equal to RESET_PC.
- R2: When no jump is offered, each out_* field equals the matching in_* field (out_ret equals in_next), out_inj is 0, out_valid equals in_valid and in_ready equals out_ready.
- R3: A jump is offered only when the last micro-op accepted from the input had in_eoi=1, or had one of the other opening conditions in R4 and R5. After a micro-op with none of these conditions, a pending request waits.
- R4: With ALLOW_MID=1, a micro-op with in_ipt=1 opens an injection point even when in_eoi=0.
- R5: A micro-op whose opcode MSB is 1 (branch class) opens an injection point even when in_eoi and in_ipt are 0.
- R6: The jump carries out_op=INJ_OP, out_addr=handler_addr and out_ret equal to the in_next value of the micro-op that opened the point. It also carries out_inj=1, out_eoi=1, out_ipt=0 and out_exc=0.
- R7: While a jump is offered, in_ready is 0. The stalled input micro-op is the next one to appear on the output.
- R8: irq_ack is high for exactly the cycle in which the jump is taken (out_valid and out_ready both high). While out_ready is low, the jump stays offered with stable fields.
- R9: A request that arrives while irq_en is 0 produces no jump. It stays pending and is injected once irq_en is 1 at an injection point.
- R10: A micro-op with in_exc=1 passes through with all fields unchanged, and it never opens an injection point, even when in_eoi=1.
- R11: Once a jump is taken, a further injection waits until a new opening micro-op has been accepted from the input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_en | input | 1 | Global interrupt enable |
| irq_req | input | 1 | Interrupt request, latched on any cycle it is high |
| irq_ack | output | 1 | One-cycle pulse when the jump is taken downstream |
| handler_addr | input | ADDR_W | Jump target for injected micro-ops |
| in_valid | input | 1 | Input micro-op valid |
| in_ready | output | 1 | Input micro-op accepted |
| in_op | input | OP_W | Opcode; MSB=1 means branch class |
| in_addr | input | ADDR_W | Parent instruction address |
| in_next | input | ADDR_W | Resume address after this micro-op |
| in_eoi | input | 1 | Last micro-op of its instruction |
| in_ipt | input | 1 | Interruptible point inside a long instruction |
| in_exc | input | 1 | Synchronous exception tag |
| out_valid | output | 1 | Output micro-op valid |
| out_ready | input | 1 | Downstream accepts output |
| out_op | output | OP_W | Output opcode |
| out_addr | output | ADDR_W | Instruction address, or handler target for a jump |
| out_ret | output | ADDR_W | Resume address, or return address for a jump |
| out_eoi | output | 1 | End-of-instruction tag |
| out_ipt | output | 1 | Interruptible-point tag |
| out_exc | output | 1 | Exception tag |
| out_inj | output | 1 | Marks an injected jump |

## Verification
All outputs are combinational in the current state and inputs, so the stream fields, in_ready and irq_ack are checked in the same cycle in which the inputs are applied. The latched request and the boundary state are registers, so a request pulse first shows as a jump one clock edge later, and an opening micro-op takes effect in the cycle after it is accepted. The bench drives at the falling edge, samples 2 ns later, and lines up each expectation with those one-edge delays. The main sweep covers all 16 combinations of the end, safe-point, branch and exception tags on the micro-op that comes before a pending request.

// File: rtl/uinj_pkg.sv
package uinj_pkg;

   typedef enum logic [1:0] {
      SRC_NONE = 2'd0,
      SRC_PASS = 2'd1,
      SRC_JUMP = 2'd2
   } uinj_src_e;

   function automatic uinj_src_e uinj_pick(input logic jump_go, input logic stream_v);
      if (jump_go)       return SRC_JUMP;
      else if (stream_v) return SRC_PASS;
      else               return SRC_NONE;
   endfunction

endpackage

// File: rtl/uinj_bnd_track.sv
module uinj_bnd_track #(
   parameter int          ADDR_W       = 32,
   parameter bit          ALLOW_MID    = 1'b1,
   parameter bit          BRANCH_OPENS = 1'b1,
   parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              xfer_in,
   input  logic              in_br,
   input  logic [ADDR_W-1:0] in_next,
   input  logic              in_eoi,
   input  logic              in_ipt,
   input  logic              in_exc,
   input  logic              inj_fire,
   output logic              at_bnd,
   output logic [ADDR_W-1:0] resume_pc
);

   logic mid_hit;
   logic br_hit;
   logic opens;

   generate
      if (ALLOW_MID) begin : g_mid_on
         assign mid_hit = in_ipt;
      end else begin : g_mid_off
         logic unused_ipt;
         assign unused_ipt = in_ipt;
         assign mid_hit    = 1'b0;
      end
      if (BRANCH_OPENS) begin : g_br_on
         assign br_hit = in_br;
      end else begin : g_br_off
         logic unused_br;
         assign unused_br = in_br;
         assign br_hit    = 1'b0;
      end
   endgenerate

   assign opens = (in_eoi | mid_hit | br_hit) & ~in_exc;

   logic              bnd_q;
   logic [ADDR_W-1:0] res_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bnd_q <= 1'b1;
         res_q <= RESET_PC;
      end else if (inj_fire) begin
         bnd_q <= 1'b0;
      end else if (xfer_in) begin
         bnd_q <= opens;
         if (opens) res_q <= in_next;
      end
   end

   assign at_bnd    = bnd_q;
   assign resume_pc = res_q;

   p_exc_closes_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_in && in_exc && !inj_fire) |=> !at_bnd)
      else $error("exception micro-op opened an injection point");

   p_plain_closes_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_in && !in_eoi && !in_ipt && !in_br && !inj_fire) |=> !at_bnd)
      else $error("plain micro-op left an injection point open");

endmodule

// File: rtl/uinj_pending.sv
module uinj_pending (
   input  logic clk,
   input  logic rst_n,
   input  logic irq_req,
   input  logic irq_en,
   input  logic at_bnd,
   input  logic out_ready,
   output logic inj_go,
   output logic inj_fire
);

   logic pend_q;
   logic offer_q;

   assign inj_go   = pend_q & at_bnd & (irq_en | offer_q);
   assign inj_fire = inj_go & out_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q  <= 1'b0;
         offer_q <= 1'b0;
      end else begin
         pend_q  <= irq_req | (pend_q & ~inj_fire);
         offer_q <= inj_go & ~out_ready;
      end
   end

   p_pend_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q && !inj_fire) |=> pend_q)
      else $error("pending request was dropped before delivery");

   p_fire_needs_pend_r3: assert property (@(posedge clk) disable iff (!rst_n)
      inj_fire |-> (pend_q && at_bnd))
      else $error("jump fired without a pending request at a boundary");

endmodule

// File: rtl/uinj_merge.sv
module uinj_merge
   import uinj_pkg::*;
#(
   parameter int               ADDR_W = 32,
   parameter int               OP_W   = 8,
   parameter logic [OP_W-1:0]  INJ_OP = '1
) (
   input  logic              inj_go,
   input  logic [ADDR_W-1:0] handler_addr,
   input  logic [ADDR_W-1:0] resume_pc,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [OP_W-1:0]   in_op,
   input  logic [ADDR_W-1:0] in_addr,
   input  logic [ADDR_W-1:0] in_next,
   input  logic              in_eoi,
   input  logic              in_ipt,
   input  logic              in_exc,
   output logic              xfer_in,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [OP_W-1:0]   out_op,
   output logic [ADDR_W-1:0] out_addr,
   output logic [ADDR_W-1:0] out_ret,
   output logic              out_eoi,
   output logic              out_ipt,
   output logic              out_exc,
   output logic              out_inj
);

   uinj_src_e src;

   always_comb begin
      src       = uinj_pick(inj_go, in_valid);
      out_valid = 1'b0;
      out_op    = in_op;
      out_addr  = in_addr;
      out_ret   = in_next;
      out_eoi   = in_eoi;
      out_ipt   = in_ipt;
      out_exc   = in_exc;
      out_inj   = 1'b0;
      unique case (src)
         SRC_JUMP: begin
            out_valid = 1'b1;
            out_op    = INJ_OP;
            out_addr  = handler_addr;
            out_ret   = resume_pc;
            out_eoi   = 1'b1;
            out_ipt   = 1'b0;
            out_exc   = 1'b0;
            out_inj   = 1'b1;
         end
         SRC_PASS: out_valid = 1'b1;
         default:  out_valid = 1'b0;
      endcase
   end

   assign in_ready = out_ready & ~inj_go;
   assign xfer_in  = in_valid & in_ready;

endmodule

// File: rtl/uop_irq_injector.sv
module uop_irq_injector #(
   parameter int                ADDR_W       = 32,
   parameter int                OP_W         = 8,
   parameter logic [OP_W-1:0]   INJ_OP       = '1,
   parameter bit                ALLOW_MID    = 1'b1,
   parameter bit                BRANCH_OPENS = 1'b1,
   parameter logic [ADDR_W-1:0] RESET_PC     = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              irq_en,
   input  logic              irq_req,
   output logic              irq_ack,
   input  logic [ADDR_W-1:0] handler_addr,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [OP_W-1:0]   in_op,
   input  logic [ADDR_W-1:0] in_addr,
   input  logic [ADDR_W-1:0] in_next,
   input  logic              in_eoi,
   input  logic              in_ipt,
   input  logic              in_exc,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [OP_W-1:0]   out_op,
   output logic [ADDR_W-1:0] out_addr,
   output logic [ADDR_W-1:0] out_ret,
   output logic              out_eoi,
   output logic              out_ipt,
   output logic              out_exc,
   output logic              out_inj
);

   localparam int BR_BIT = OP_W - 1;

   generate
      if (ADDR_W < 2) begin : g_bad_aw
         $error("ADDR_W must be at least 2");
      end
      if (OP_W < 2) begin : g_bad_ow
         $error("OP_W must be at least 2");
      end
      if (BRANCH_OPENS && !INJ_OP[BR_BIT]) begin : g_bad_op
         $error("INJ_OP must be branch class (MSB set)");
      end
   endgenerate

   logic              at_bnd;
   logic [ADDR_W-1:0] resume_pc;
   logic              inj_go;
   logic              inj_fire;
   logic              xfer_in;

   uinj_bnd_track #(
      .ADDR_W      (ADDR_W),
      .ALLOW_MID   (ALLOW_MID),
      .BRANCH_OPENS(BRANCH_OPENS),
      .RESET_PC    (RESET_PC)
   ) bnd_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .xfer_in  (xfer_in),
      .in_br    (in_op[BR_BIT]),
      .in_next  (in_next),
      .in_eoi   (in_eoi),
      .in_ipt   (in_ipt),
      .in_exc   (in_exc),
      .inj_fire (inj_fire),
      .at_bnd   (at_bnd),
      .resume_pc(resume_pc)
   );

   uinj_pending pend_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .irq_req  (irq_req),
      .irq_en   (irq_en),
      .at_bnd   (at_bnd),
      .out_ready(out_ready),
      .inj_go   (inj_go),
      .inj_fire (inj_fire)
   );

   uinj_merge #(
      .ADDR_W(ADDR_W),
      .OP_W  (OP_W),
      .INJ_OP(INJ_OP)
   ) merge_i (
      .inj_go      (inj_go),
      .handler_addr(handler_addr),
      .resume_pc   (resume_pc),
      .in_valid    (in_valid),
      .in_ready    (in_ready),
      .in_op       (in_op),
      .in_addr     (in_addr),
      .in_next     (in_next),
      .in_eoi      (in_eoi),
      .in_ipt      (in_ipt),
      .in_exc      (in_exc),
      .xfer_in     (xfer_in),
      .out_valid   (out_valid),
      .out_ready   (out_ready),
      .out_op      (out_op),
      .out_addr    (out_addr),
      .out_ret     (out_ret),
      .out_eoi     (out_eoi),
      .out_ipt     (out_ipt),
      .out_exc     (out_exc),
      .out_inj     (out_inj)
   );

   assign irq_ack = inj_fire;

   p_ack_taken_r8: assert property (@(posedge clk) disable iff (!rst_n)
      irq_ack |-> (out_valid && out_ready && out_inj))
      else $error("acknowledge without a taken jump");

   p_hold_jump_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_inj && !out_ready) |=> (out_valid && out_inj && $stable(out_ret)))
      else $error("offered jump withdrawn or changed");

   p_jump_target_r6: assert property (@(posedge clk) disable iff (!rst_n)
      out_inj |-> (out_addr == handler_addr && out_op == INJ_OP && !out_exc))
      else $error("jump fields wrong");

   p_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
      out_inj |-> !in_ready)
      else $error("input accepted while jump offered");

   p_after_ack_r11: assert property (@(posedge clk) disable iff (!rst_n)
      irq_ack |=> !out_inj)
      else $error("back-to-back jumps without a new boundary");

   p_no_inj_disabled_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!irq_en && !$past(out_valid && out_inj && !out_ready)) |-> !out_inj)
      else $error("jump started while interrupts disabled");

endmodule

// File: tb/uop_irq_injector_tb_top.sv
module uop_irq_injector_tb_top;

   localparam int         AW  = 8;
   localparam int         OW  = 4;
   localparam logic [3:0] INJ = 4'hF;
   localparam logic [7:0] RPC = 8'h10;
   localparam logic [7:0] HND = 8'hC4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          irq_en = 1'b0, irq_req = 1'b0, irq_ack;
   logic [AW-1:0] handler_addr = HND;
   logic          in_valid = 1'b0, in_ready;
   logic [OW-1:0] in_op = '0;
   logic [AW-1:0] in_addr = '0, in_next = '0;
   logic          in_eoi = 1'b0, in_ipt = 1'b0, in_exc = 1'b0;
   logic          out_valid, out_ready = 1'b1;
   logic [OW-1:0] out_op;
   logic [AW-1:0] out_addr, out_ret;
   logic          out_eoi, out_ipt, out_exc, out_inj;

   int checks = 0;
   int fails  = 0;

   always #10 clk = ~clk;

   uop_irq_injector #(
      .ADDR_W(AW), .OP_W(OW), .INJ_OP(INJ),
      .ALLOW_MID(1'b1), .BRANCH_OPENS(1'b1), .RESET_PC(RPC)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .irq_en(irq_en), .irq_req(irq_req), .irq_ack(irq_ack),
      .handler_addr(handler_addr), .in_valid(in_valid), .in_ready(in_ready),
      .in_op(in_op), .in_addr(in_addr), .in_next(in_next), .in_eoi(in_eoi),
      .in_ipt(in_ipt), .in_exc(in_exc), .out_valid(out_valid), .out_ready(out_ready),
      .out_op(out_op), .out_addr(out_addr), .out_ret(out_ret), .out_eoi(out_eoi),
      .out_ipt(out_ipt), .out_exc(out_exc), .out_inj(out_inj)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic drive(input logic v, input logic [3:0] op, input logic [7:0] a,
                        input logic [7:0] nx, input logic e, input logic i, input logic x,
                        input logic ordy, input logic req, input logic en);
      @(negedge clk);
      in_valid = v; in_op = op; in_addr = a; in_next = nx;
      in_eoi = e; in_ipt = i; in_exc = x;
      out_ready = ordy; irq_req = req; irq_en = en;
      #2;
   endtask

   task automatic idle(input logic ordy, input logic req, input logic en);
      drive(1'b0, 4'h0, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, ordy, req, en);
   endtask

   initial begin
      #(20 * 100000);
      fails++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state and injection straight after reset
      idle(1'b1, 1'b0, 1'b1);
      chk("R1 out_valid idle", out_valid, 0);
      chk("R1 ack idle", irq_ack, 0);
      chk("R1 in_ready", in_ready, 1);
      idle(1'b1, 1'b1, 1'b1);
      chk("R1 no jump before latch", out_inj, 0);
      idle(1'b1, 1'b0, 1'b1);
      chk("R1 jump after reset", out_inj, 1);
      chk("R1 return RESET_PC", out_ret, RPC);
      chk("R1 ack", irq_ack, 1);

      // R3 R4 R5 R10 sweep over the tags of the micro-op before a request
      for (int k = 0; k < 16; k++) begin
         logic       e, i, b, x, opens;
         logic [3:0] op;
         logic [7:0] nx;
         string      tag;
         e = k[0]; i = k[1]; b = k[2]; x = k[3];
         op = b ? 4'h9 : 4'h1;
         nx = 8'h40 + 8'(k);
         opens = (e | i | b) & ~x;
         tag = x ? "R10" : (b && !e && !i) ? "R5" : (i && !e) ? "R4" : "R3";

         drive(1'b1, op, 8'h20 + 8'(k), nx, e, i, x, 1'b1, 1'b0, 1'b1);
         chk("R2 pass valid", out_valid, 1);
         chk("R2 pass not jump", out_inj, 0);
         chk("R2 pass addr", out_addr, 8'h20 + 8'(k));
         chk("R2 pass op", out_op, op);
         chk("R2 pass ret", out_ret, nx);
         chk("R10 exc tag kept", out_exc, x);
         chk("R2 in_ready", in_ready, 1);

         idle(1'b1, 1'b1, 1'b1);
         chk("R2 idle", out_valid, 0);

         drive(1'b1, 4'h2, 8'h30, 8'h31, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1);
         if (opens) begin
            chk({tag, " jump offered"}, out_inj, 1);
            chk("R6 ret", out_ret, nx);
            chk("R6 target", out_addr, HND);
            chk("R6 op", out_op, INJ);
            chk("R6 eoi", out_eoi, 1);
            chk("R7 stall", in_ready, 0);
            chk("R8 ack", irq_ack, 1);
            drive(1'b1, 4'h2, 8'h30, 8'h31, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1);
            chk("R7 held uop next", out_addr, 8'h30);
            chk("R7 no jump", out_inj, 0);
            chk("R7 ready", in_ready, 1);
         end else begin
            chk({tag, " no jump"}, out_inj, 0);
            chk({tag, " ready"}, in_ready, 1);
            chk({tag, " no ack"}, irq_ack, 0);
            drive(1'b1, 4'h3, 8'h50, 8'h51, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1);
            chk("R3 mid stream waits", out_inj, 0);
            idle(1'b1, 1'b0, 1'b1);
            chk("R3 jump after end", out_inj, 1);
            chk("R3 ret from end uop", out_ret, 8'h51);
         end
      end

      // R11: after a taken jump, wait for a new opening micro-op
      idle(1'b1, 1'b1, 1'b1);
      idle(1'b1, 1'b0, 1'b1);
      chk("R11 no jump without boundary", out_inj, 0);
      drive(1'b1, 4'h2, 8'h60, 8'h61, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1);
      chk("R11 mid uop passes", out_addr, 8'h60);
      drive(1'b1, 4'h3, 8'h76, 8'h77, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1);
      chk("R11 end uop passes", out_inj, 0);
      idle(1'b1, 1'b0, 1'b1);
      chk("R11 jump", out_inj, 1);
      chk("R11 ret", out_ret, 8'h77);

      // R9 and R8: enable gating and downstream stall
      drive(1'b1, 4'h3, 8'h87, 8'h88, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1);
      idle(1'b1, 1'b1, 1'b0);
      for (int n = 0; n < 3; n++) begin
         idle(1'b1, 1'b0, 1'b0);
         chk("R9 disabled no jump", out_inj, 0);
      end
      idle(1'b0, 1'b0, 1'b1);
      chk("R9 jump once enabled", out_inj, 1);
      chk("R8 no ack while stalled", irq_ack, 0);
      idle(1'b0, 1'b0, 1'b1);
      chk("R8 jump held", out_valid & out_inj, 1);
      chk("R8 ret stable", out_ret, 8'h88);
      idle(1'b1, 1'b0, 1'b1);
      chk("R8 ack on take", irq_ack, 1);
      idle(1'b1, 1'b0, 1'b1);
      chk("R8 ack single pulse", irq_ack, 0);
      chk("R8 no repeat", out_valid, 0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule